// File: doc/BRIEF.md
# Modem Status and Interrupt Register

This block holds the status word that a microcontroller reads from a packet modem. It keeps three handshake flags: a data-buffer-free flag, an interleave-empty flag for the transmit side and a receive overflow flag. It also keeps a sticky interrupt-request bit and drives an active-low interrupt pin. The flags are set by event pulses from the datapath and cleared by task writes, status reads, a reset task or a change of the operating mode.

A rising flag normally raises the interrupt request. A flag raised by a reset task, or by a change of the transmit/receive or power-save mode bits, is set silently. The request bit clears on a status read. If a read and a new event fall in the same cycle, the event wins. While the transmit interleave buffer is nearly empty, a bias-hold output tells the transmit path to output its mid-level value.

Top module: `mdm_stat_reg`

## Requirements
- R1: After synchronous reset the status word shows buffer-free = 1, interleave-empty = the transmit-mode bit, overflow = 0 and request = 0. The interrupt pin is high.
- R2: Status bit 7 is the request, bit 6 buffer-free, bit 5 interleave-empty, bit 4 overflow, bit 3 data-quality-ready, bit 2 always 0, bit 1 the CRC flag and bit 0 the misc flag. Bits 3, 1 and 0 are the registered inputs, one cycle late.
- R3: Buffer-free is set by the transmitter-ready pulse in transmit mode and by the receive-done pulse in receive mode. The pulse of the other mode has no effect. A 0-to-1 change of the flag sets the request.
- R4: In transmit mode, interleave-empty is set, together with the request, when the bit count drops from 2 or more to below 2. In receive mode the flag reads 0.
- R5: In receive mode a late-task pulse sets overflow and the request. Overflow clears on a status read, on a RESET task or on a mode change. Overflow reads 0 in transmit mode.
- R6: A 0-to-1 change of the data-quality input sets the request only while the dq-enable mode bit is 1.
- R7: A RESET task (code 0x1), or a change of the power-save or transmit/receive bit, sets buffer-free and, in transmit mode, interleave-empty, without setting the request.
- R8: A task write with a code other than 0x0, 0x1 or 0x2 clears buffer-free and interleave-empty. Codes 0x0 and 0x2 leave both flags unchanged.
- R9: A status read clears the request, unless an event that sets the request occurs in the same cycle. In that case the request stays 1, and an overflow event in that cycle leaves overflow at 1.
- R10: The interrupt pin is low exactly when the request is 1 and the irq-enable mode bit is 1.
- R11: Bias-hold is high exactly when in transmit mode and the interleave bit count is below 2.
- R12: An event on a flag that is already 1 does not set the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | Status read strobe |
| cmd_wr | input | 1 | Task write strobe |
| cmd_task | input | 4 | Task code |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| mode_psave | input | 1 | Power-save mode bit |
| mode_irq_en | input | 1 | Interrupt pin enable |
| mode_dq_en | input | 1 | Data-quality interrupt enable |
| ev_tx_ready | input | 1 | Transmitter ready for data pulse |
| ev_rx_done | input | 1 | Receive task complete pulse |
| ev_rx_late | input | 1 | Receive task written too late pulse |
| ilv_bits | input | 8 | Bits left in the interleave buffer |
| dq_flag | input | 1 | Data-quality ready level |
| crc_flag | input | 1 | CRC/FEC flag level |
| misc_flag | input | 1 | Misc status level |
| status | output | 8 | Status word |
| irq_n | output | 1 | Active-low interrupt |
| bias_hold | output | 1 | Transmit mid-level hold |

## Verification
Every one of the sixteen task codes is written after a RESET task, which separates the codes that clear flags from those that do not. The interrupt logic is tried with flag-setting events in each mode, events on flags already set, silent sets from reset tasks and mode changes, and a read that coincides with an event. These patterns separate a real rising edge from a level and separate silent sets from events that interrupt. The interleave count is swept across the threshold in both modes, and the interrupt pin and data-quality interrupt are tried with their enables both on and off.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;

    localparam int TASK_W = 4;
    localparam int IBW    = 8;
    localparam int IB_LIM = 2;

    localparam logic [TASK_W-1:0] TASK_NULL  = 4'h0;
    localparam logic [TASK_W-1:0] TASK_RESET = 4'h1;
    localparam logic [TASK_W-1:0] TASK_TSO   = 4'h2;

    typedef struct packed {
        logic irq;
        logic bfree;
        logic ibempty;
        logic dibovf;
        logic dqrdy;
        logic rsvd;
        logic crc;
        logic misc;
    } stat_word_t;

    typedef struct packed {
        logic task_clr;
        logic task_rst;
        logic mode_chg;
        logic silent;
    } ctl_t;

    typedef struct packed {
        logic bfree;
        logic ibempty;
        logic dibovf;
    } rise_t;

    function automatic logic task_clears(input logic [TASK_W-1:0] t);
        return !(t == TASK_NULL || t == TASK_RESET || t == TASK_TSO);
    endfunction

endpackage

// File: rtl/mdm_ctl_decode.sv
module mdm_ctl_decode
    import mdm_stat_pkg::*;
#(
    parameter int BITS_W = IBW,
    parameter int LIMIT  = IB_LIM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [TASK_W-1:0] cmd_task,
    input  logic              mode_tx,
    input  logic              mode_psave,
    input  logic [BITS_W-1:0] ilv_bits,
    output ctl_t              ctl,
    output logic              ilv_low,
    output logic              low_edge
);

    logic tx_q, ps_q, low_q;

    always_comb begin
        ilv_low      = (ilv_bits < BITS_W'(LIMIT));
        low_edge     = ilv_low && !low_q;
        ctl.task_rst = cmd_wr && (cmd_task == TASK_RESET);
        ctl.task_clr = cmd_wr && task_clears(cmd_task);
        ctl.mode_chg = (mode_tx != tx_q) || (mode_psave != ps_q);
        ctl.silent   = ctl.task_rst || ctl.mode_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= mode_tx;
            ps_q  <= mode_psave;
            low_q <= ilv_low;
        end else begin
            tx_q  <= mode_tx;
            ps_q  <= mode_psave;
            low_q <= ilv_low;
        end
    end

endmodule

// File: rtl/mdm_flag_bank.sv
module mdm_flag_bank
    import mdm_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  logic  mode_tx,
    input  logic  ev_tx_ready,
    input  logic  ev_rx_done,
    input  logic  ev_rx_late,
    input  logic  low_edge,
    input  logic  stat_rd,
    output logic  bfree,
    output logic  ibempty,
    output logic  dibovf,
    output rise_t rise
);

    logic ev_set;
    logic bfree_n, ibempty_n, dibovf_n;

    always_comb begin
        ev_set = mode_tx ? ev_tx_ready : ev_rx_done;

        if (ctl.silent)        bfree_n = 1'b1;
        else if (ev_set)       bfree_n = 1'b1;
        else if (ctl.task_clr) bfree_n = 1'b0;
        else                   bfree_n = bfree;

        if (!mode_tx)          ibempty_n = 1'b0;
        else if (ctl.silent)   ibempty_n = 1'b1;
        else if (low_edge)     ibempty_n = 1'b1;
        else if (ctl.task_clr) ibempty_n = 1'b0;
        else                   ibempty_n = ibempty;

        if (mode_tx)           dibovf_n = 1'b0;
        else if (ctl.silent)   dibovf_n = 1'b0;
        else if (ev_rx_late)   dibovf_n = 1'b1;
        else if (stat_rd)      dibovf_n = 1'b0;
        else                   dibovf_n = dibovf;

        rise.bfree   = !ctl.silent && ev_set && !bfree;
        rise.ibempty = mode_tx && !ctl.silent && low_edge && !ibempty;
        rise.dibovf  = !mode_tx && !ctl.silent && ev_rx_late && !dibovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bfree   <= 1'b1;
            ibempty <= mode_tx;
            dibovf  <= 1'b0;
        end else begin
            bfree   <= bfree_n;
            ibempty <= ibempty_n;
            dibovf  <= dibovf_n;
        end
    end

    // R4: interleave-empty reads 0 after a receive-mode cycle
    a_r4_rx_ib_zero: assert property (@(posedge clk) disable iff (rst)
        !mode_tx |=> !ibempty);

    // R5: overflow reads 0 after a transmit-mode cycle
    a_r5_tx_no_ovf: assert property (@(posedge clk) disable iff (rst)
        mode_tx |=> !dibovf);

    // R7: silent causes always leave buffer-free set
    a_r7_silent_sets: assert property (@(posedge clk) disable iff (rst)
        ctl.silent |=> bfree);

    // R8: a clearing task with no competing set drops buffer-free
    a_r8_task_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl.task_clr && !ctl.silent && !ev_set) |=> !bfree);

endmodule

// File: rtl/mdm_irq_ctl.sv
module mdm_irq_ctl
    import mdm_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rise_t rise,
    input  logic  dq_flag,
    input  logic  dq_en,
    input  logic  stat_rd,
    input  logic  irq_en,
    output logic  irq,
    output logic  dqrdy,
    output logic  irq_n
);

    logic dq_rise, any_rise;

    always_comb begin
        dq_rise  = dq_flag && !dqrdy && dq_en;
        any_rise = (|rise) || dq_rise;
        irq_n    = !(irq && irq_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq   <= 1'b0;
            dqrdy <= 1'b0;
        end else begin
            dqrdy <= dq_flag;
            if (any_rise)     irq <= 1'b1;
            else if (stat_rd) irq <= 1'b0;
        end
    end

    // R9: a read with no coinciding event clears the request
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !any_rise) |=> !irq);

    // R12: the request only rises after a real flag edge
    a_r12_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(any_rise));

    // R6: with dq disabled and no flag edge an idle request stays idle
    a_r6_dq_gated: assert property (@(posedge clk) disable iff (rst)
        (!irq && !dq_en && rise == '0) |=> !irq);

endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
    import mdm_stat_pkg::*;
#(
    parameter int BITS_W = IBW,
    parameter int LIMIT  = IB_LIM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rd,
    input  logic              cmd_wr,
    input  logic [TASK_W-1:0] cmd_task,
    input  logic              mode_tx,
    input  logic              mode_psave,
    input  logic              mode_irq_en,
    input  logic              mode_dq_en,
    input  logic              ev_tx_ready,
    input  logic              ev_rx_done,
    input  logic              ev_rx_late,
    input  logic [BITS_W-1:0] ilv_bits,
    input  logic              dq_flag,
    input  logic              crc_flag,
    input  logic              misc_flag,
    output logic [7:0]        status,
    output logic              irq_n,
    output logic              bias_hold
);

    ctl_t       ctl;
    rise_t      rise;
    stat_word_t word;
    logic       ilv_low, low_edge;
    logic       bfree, ibempty, dibovf, irq, dqrdy;
    logic       crc_q, misc_q;

    mdm_ctl_decode #(.BITS_W(BITS_W), .LIMIT(LIMIT)) u_dec (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_task(cmd_task),
        .mode_tx(mode_tx), .mode_psave(mode_psave), .ilv_bits(ilv_bits),
        .ctl(ctl), .ilv_low(ilv_low), .low_edge(low_edge)
    );

    mdm_flag_bank u_flags (
        .clk(clk), .rst(rst), .ctl(ctl), .mode_tx(mode_tx),
        .ev_tx_ready(ev_tx_ready), .ev_rx_done(ev_rx_done),
        .ev_rx_late(ev_rx_late), .low_edge(low_edge), .stat_rd(stat_rd),
        .bfree(bfree), .ibempty(ibempty), .dibovf(dibovf), .rise(rise)
    );

    mdm_irq_ctl u_irq (
        .clk(clk), .rst(rst), .rise(rise), .dq_flag(dq_flag),
        .dq_en(mode_dq_en), .stat_rd(stat_rd), .irq_en(mode_irq_en),
        .irq(irq), .dqrdy(dqrdy), .irq_n(irq_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= 1'b0;
            misc_q <= 1'b0;
        end else begin
            crc_q  <= crc_flag;
            misc_q <= misc_flag;
        end
    end

    always_comb begin
        word.irq     = irq;
        word.bfree   = bfree;
        word.ibempty = ibempty;
        word.dibovf  = dibovf;
        word.dqrdy   = dqrdy;
        word.rsvd    = 1'b0;
        word.crc     = crc_q;
        word.misc    = misc_q;
        status       = word;
        bias_hold    = mode_tx && ilv_low;
    end

    // R10: the pin is released whenever the request is clear
    a_r10_pin_idle: assert property (@(posedge clk) disable iff (rst)
        !status[7] |-> irq_n);

endmodule

// File: tb/mdm_stat_reg_bench.sv
module mdm_stat_reg_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stat_rd = 0, cmd_wr = 0;
    logic [3:0] cmd_task = 0;
    logic       mode_tx = 1, mode_psave = 0, mode_irq_en = 1, mode_dq_en = 0;
    logic       ev_tx_ready = 0, ev_rx_done = 0, ev_rx_late = 0;
    logic [7:0] ilv_bits = 8'd10;
    logic       dq_flag = 0, crc_flag = 0, misc_flag = 0;
    logic [7:0] status;
    logic       irq_n, bias_hold;

    int n_run = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    mdm_stat_reg u_mdm_stat_reg (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .cmd_wr(cmd_wr),
        .cmd_task(cmd_task), .mode_tx(mode_tx), .mode_psave(mode_psave),
        .mode_irq_en(mode_irq_en), .mode_dq_en(mode_dq_en),
        .ev_tx_ready(ev_tx_ready), .ev_rx_done(ev_rx_done),
        .ev_rx_late(ev_rx_late), .ilv_bits(ilv_bits), .dq_flag(dq_flag),
        .crc_flag(crc_flag), .misc_flag(misc_flag),
        .status(status), .irq_n(irq_n), .bias_hold(bias_hold)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_task(input logic [3:0] c);
        cmd_wr = 1; cmd_task = c; step(); cmd_wr = 0;
    endtask

    task automatic do_rd();
        stat_rd = 1; step(); stat_rd = 0;
    endtask

    initial begin
        #(CLK_P*100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(); step(); rst = 0;
        // R1 reset state
        chk("R1 status", status, 8'h60);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // R8 sweep of every task code
        for (int c = 0; c < 16; c++) begin
            do_task(4'h1);
            do_task(c[3:0]);
            chk($sformatf("R8 code %0d", c), {5'b0, status[7:5]},
                (c <= 2) ? 8'h03 : 8'h00);
        end

        // R3 transmit mode
        ev_rx_done = 1; step(); ev_rx_done = 0;
        chk("R3 rx_done ignored in tx", {6'b0, status[7:6]}, 8'h00);
        ev_tx_ready = 1; step(); ev_tx_ready = 0;
        chk("R3 tx_ready sets", {6'b0, status[7:6]}, 8'h03);
        chk("R10 pin low", {7'b0, irq_n}, 8'h00);
        do_rd();
        chk("R9 read clears", {6'b0, status[7:6]}, 8'h01);
        // R12 no rise when already set
        ev_tx_ready = 1; step(); ev_tx_ready = 0;
        chk("R12 no repeat irq", {7'b0, status[7]}, 8'h00);

        // R10 enable off
        mode_irq_en = 0;
        do_task(4'h3);
        ev_tx_ready = 1; step(); ev_tx_ready = 0;
        chk("R10 request set", {7'b0, status[7]}, 8'h01);
        chk("R10 pin masked", {7'b0, irq_n}, 8'h01);
        mode_irq_en = 1; #1;
        chk("R10 pin enabled", {7'b0, irq_n}, 8'h00);
        do_rd();

        // R4 interleave threshold
        do_task(4'h3);
        ilv_bits = 8'd1; step();
        chk("R4 ib set", {6'b0, status[7], status[5]}, 8'h03);
        do_rd();
        do_task(4'h3);
        chk("R4 ib cleared by task", {7'b0, status[5]}, 8'h00);
        ilv_bits = 8'd10; step();

        // R11 bias sweep
        for (int b = 0; b < 6; b++) begin
            ilv_bits = b[7:0]; #1;
            chk($sformatf("R11 bits %0d", b), {7'b0, bias_hold}, (b < 2) ? 8'h01 : 8'h00);
            step();
        end
        ilv_bits = 8'd10; step(); do_rd();

        // R7 power-save change
        do_task(4'h3);
        chk("R7 pre clear", {5'b0, status[7:5]}, 8'h00);
        mode_psave = 1; step();
        chk("R7 psave silent", {5'b0, status[7:5]}, 8'h03);
        mode_psave = 0; step();

        // R5 late in tx ignored
        ev_rx_late = 1; step(); ev_rx_late = 0;
        chk("R5 tx no overflow", {6'b0, status[7], status[4]}, 8'h00);

        // switch to receive
        mode_tx = 0; step();
        chk("R7 mode change to rx", {4'b0, status[7:4]}, 8'h04);
        ilv_bits = 8'd0; step();
        chk("R4 rx ib held", {7'b0, status[5]}, 8'h00);
        chk("R11 rx no bias", {7'b0, bias_hold}, 8'h00);
        ilv_bits = 8'd10; step();

        // R3 receive mode
        do_task(4'h3);
        ev_tx_ready = 1; step(); ev_tx_ready = 0;
        chk("R3 tx_ready ignored in rx", {6'b0, status[7:6]}, 8'h00);
        ev_rx_done = 1; step(); ev_rx_done = 0;
        chk("R3 rx_done sets", {6'b0, status[7:6]}, 8'h03);
        do_rd();

        // R5 overflow
        ev_rx_late = 1; step(); ev_rx_late = 0;
        chk("R5 late sets", {6'b0, status[7], status[4]}, 8'h03);
        do_rd();
        chk("R5 read clears", {6'b0, status[7], status[4]}, 8'h00);
        ev_rx_late = 1; step(); ev_rx_late = 0;
        do_task(4'h1);
        chk("R5 reset task clears", {6'b0, status[7], status[4]}, 8'h02);
        do_rd();
        // R9 collision
        ev_rx_late = 1; stat_rd = 1; step(); ev_rx_late = 0; stat_rd = 0;
        chk("R9 event wins", {6'b0, status[7], status[4]}, 8'h03);
        do_rd();
        ev_rx_late = 1; step(); ev_rx_late = 0;
        mode_psave = 1; step();
        chk("R5 mode change clears", {7'b0, status[4]}, 8'h00);
        mode_psave = 0; step(); do_rd();

        // R6 data quality
        mode_dq_en = 0; dq_flag = 1; step();
        chk("R6 dq masked", {6'b0, status[7], status[3]}, 8'h01);
        dq_flag = 0; step();
        mode_dq_en = 1; dq_flag = 1; step();
        chk("R6 dq enabled", {6'b0, status[7], status[3]}, 8'h03);
        do_rd(); dq_flag = 0; step();

        // R2 low bits
        crc_flag = 1; misc_flag = 0; step();
        chk("R2 crc bit", {5'b0, status[2:0]}, 8'h02);
        crc_flag = 0; misc_flag = 1; step();
        chk("R2 misc bit", {5'b0, status[2:0]}, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule